// File: doc/BRIEF.md
# Profile-Switched DDS Phase Accumulator

This block is the numerically controlled oscillator core of a direct digital synthesizer. A 48-bit accumulator adds a frequency tuning word on every clock. The upper 14 bits of the accumulator, plus a 14-bit phase offset, form the phase word that a later sine lookup and DAC stage consume. Eight profiles each hold their own tuning word and phase offset. A three-bit select input picks the profile that drives the accumulator.

Software writes through a plain register port into shadow copies. Nothing reaches the datapath until an update strobe commits every shadow register at once, so a multi-word change takes effect on a single edge. An optional sweep mode replaces the profile tuning word with a ramp. The ramp starts from the selected profile's word and adds a programmable step at a programmable interval, stopping at an end limit. A phase-clear input restarts the accumulator without touching any register.

Top module: `dds_profile_nco`

## Requirements
- R1: While `rst_ni` is low, `phase_o` is 0. Reset clears the accumulator, every shadow and active register and the sampled profile select (profile 0).
- R2: A write with `wr_en_i` high stores into a shadow register and does not affect `phase_o` until `update_i` is sampled high. That edge copies all shadow registers to the active set. Address map: `wr_addr_i[4:3]`=0 selects the tuning word of profile `wr_addr_i[2:0]`, =1 selects the phase offset of that profile (data bits 13:0), =2 selects sweep registers by `wr_addr_i[2:0]`: 0 step, 1 end limit, 2 interval (data bits 15:0), 3 control (data bit 0 = sweep enable).
- R3: `prof_sel_i` is sampled on each rising edge, and the sampled profile's active tuning word is the one added on the following edge.
- R4: Each edge without phase clear adds the effective tuning word to the accumulator modulo 2^48. `phase_o` equals accumulator bits 47:34 plus the selected profile's active phase offset, modulo 2^14.
- R5: An edge with `phase_clr_i` high sets the accumulator to 0 and leaves all register contents unchanged. Right after that edge, `phase_o` equals the selected phase offset.
- R6: With sweep enabled, the edge that commits loads the sweep word from the shadow tuning word of the profile on `prof_sel_i`. The effective word then grows by the step every interval edges (interval 0 acts as 1).
- R7: The swept tuning word never exceeds the end limit. A step that would pass it lands on the limit.
- R8: Committing with sweep disabled returns the effective tuning word to the selected profile's active word on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Synchronisation clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 5 | Register address |
| wr_data_i | input | 48 | Register write data |
| prof_sel_i | input | 3 | Profile select |
| update_i | input | 1 | Commit shadow registers to active set |
| phase_clr_i | input | 1 | Zero the accumulator |
| phase_o | output | 14 | Output phase word |

## Verification
The hardest condition to reach from the ports is the sweep clamping at its limit. The swept word is never visible directly. The bench sets every tuning-related value to a multiple of 2^34, so that each per-cycle difference of `phase_o` equals the effective word in units of one. It then runs a ramp with interval 3 and an end limit of four steps long enough to pass the limit, and checks the increment edge by edge until it has stayed flat at the limit for several cycles.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic [1:0] {
    BANK_FTW   = 2'd0,
    BANK_POFF  = 2'd1,
    BANK_SWEEP = 2'd2,
    BANK_NONE  = 2'd3
  } bank_e;

  localparam int SW_STEP = 0;
  localparam int SW_END  = 1;
  localparam int SW_IVL  = 2;
  localparam int SW_CTRL = 3;
endpackage

// File: rtl/nco_regfile.sv
module nco_regfile
  import nco_pkg::*;
#(
  parameter int FTW_W  = 48,
  parameter int PH_W   = 14,
  parameter int N_PROF = 8,
  parameter int IVL_W  = 16,
  localparam int SEL_W  = $clog2(N_PROF),
  localparam int ADDR_W = SEL_W + 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [FTW_W-1:0]               wr_data_i,
  input  logic [SEL_W-1:0]               prof_sel_i,
  input  logic                           update_i,
  output logic [N_PROF-1:0][FTW_W-1:0]   act_ftw_o,
  output logic [SEL_W-1:0]               prof_q_o,
  output logic [FTW_W-1:0]               sel_ftw_o,
  output logic [PH_W-1:0]                sel_poff_o,
  output logic [FTW_W-1:0]               start_ftw_o,
  output logic [FTW_W-1:0]               step_o,
  output logic [FTW_W-1:0]               end_o,
  output logic [IVL_W-1:0]               ivl_o,
  output logic                           sweep_en_o
);
  logic [N_PROF-1:0][FTW_W-1:0] sh_ftw, act_ftw;
  logic [N_PROF-1:0][PH_W-1:0]  sh_poff, act_poff;
  logic [FTW_W-1:0] sh_step, act_step, sh_end, act_end;
  logic [IVL_W-1:0] sh_ivl, act_ivl;
  logic             sh_ctrl, act_ctrl;
  logic [SEL_W-1:0] prof_q;
  bank_e            bank;
  logic [SEL_W-1:0] idx;

  assign bank = bank_e'(wr_addr_i[ADDR_W-1 -: 2]);
  assign idx  = wr_addr_i[SEL_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_ftw <= '0; act_ftw <= '0; sh_poff <= '0; act_poff <= '0;
      sh_step <= '0; act_step <= '0; sh_end <= '0; act_end <= '0;
      sh_ivl <= '0; act_ivl <= '0; sh_ctrl <= 1'b0; act_ctrl <= 1'b0;
      prof_q <= '0;
    end else begin
      prof_q <= prof_sel_i;
      if (wr_en_i) begin
        case (bank)
          BANK_FTW:  sh_ftw[idx]  <= wr_data_i;
          BANK_POFF: sh_poff[idx] <= wr_data_i[PH_W-1:0];
          BANK_SWEEP: begin
            case (idx)
              SEL_W'(SW_STEP): sh_step <= wr_data_i;
              SEL_W'(SW_END):  sh_end  <= wr_data_i;
              SEL_W'(SW_IVL):  sh_ivl  <= wr_data_i[IVL_W-1:0];
              SEL_W'(SW_CTRL): sh_ctrl <= wr_data_i[0];
              default: ;
            endcase
          end
          default: ;
        endcase
      end
      if (update_i) begin
        act_ftw  <= sh_ftw;
        act_poff <= sh_poff;
        act_step <= sh_step;
        act_end  <= sh_end;
        act_ivl  <= sh_ivl;
        act_ctrl <= sh_ctrl;
      end
    end
  end

  assign act_ftw_o   = act_ftw;
  assign prof_q_o    = prof_q;
  assign sel_ftw_o   = act_ftw[prof_q];
  assign sel_poff_o  = act_poff[prof_q];
  assign start_ftw_o = sh_ftw[prof_sel_i];
  assign step_o      = act_step;
  assign end_o       = act_end;
  assign ivl_o       = act_ivl;
  assign sweep_en_o  = act_ctrl;
endmodule

// File: rtl/nco_sweep.sv
module nco_sweep #(
  parameter int FTW_W = 48,
  parameter int IVL_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             en_i,
  input  logic [FTW_W-1:0] start_i,
  input  logic [FTW_W-1:0] step_i,
  input  logic [FTW_W-1:0] end_i,
  input  logic [IVL_W-1:0] ivl_i,
  output logic [FTW_W-1:0] ftw_o,
  output logic             tick_o
);
  logic [FTW_W-1:0] ftw_q, ftw_nxt;
  logic [IVL_W-1:0] cnt_q, ivl_m1;
  logic [FTW_W:0]   sum;

  assign ivl_m1  = (ivl_i == '0) ? '0 : ivl_i - 1'b1;
  assign tick_o  = en_i && !load_i && (cnt_q >= ivl_m1);
  assign sum     = {1'b0, ftw_q} + {1'b0, step_i};
  // clamp at end limit, including carry out of the word
  assign ftw_nxt = (sum > {1'b0, end_i}) ? end_i : sum[FTW_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ftw_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      ftw_q <= start_i;
      cnt_q <= '0;
    end else if (en_i) begin
      if (tick_o) begin
        ftw_q <= ftw_nxt;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ftw_o = ftw_q;
endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int FTW_W = 48,
  parameter int PH_W  = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [FTW_W-1:0] ftw_i,
  input  logic [PH_W-1:0]  poff_i,
  output logic [FTW_W-1:0] acc_o,
  output logic [PH_W-1:0]  phase_o
);
  logic [FTW_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else             acc_q <= acc_q + ftw_i;
  end

  assign acc_o   = acc_q;
  assign phase_o = acc_q[FTW_W-1 -: PH_W] + poff_i;
endmodule

// File: rtl/dds_profile_nco.sv
module dds_profile_nco #(
  parameter int FTW_W  = 48,
  parameter int PH_W   = 14,
  parameter int N_PROF = 8,
  parameter int IVL_W  = 16,
  localparam int SEL_W  = $clog2(N_PROF),
  localparam int ADDR_W = SEL_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [FTW_W-1:0]  wr_data_i,
  input  logic [SEL_W-1:0]  prof_sel_i,
  input  logic              update_i,
  input  logic              phase_clr_i,
  output logic [PH_W-1:0]   phase_o
);
  logic [N_PROF-1:0][FTW_W-1:0] act_ftw;
  logic [SEL_W-1:0] prof_q;
  logic [FTW_W-1:0] sel_ftw, start_ftw, sw_step, sw_end, sw_ftw, ftw_eff, acc_q;
  logic [PH_W-1:0]  sel_poff;
  logic [IVL_W-1:0] sw_ivl;
  logic             sweep_en, sw_tick;

  nco_regfile #(.FTW_W(FTW_W), .PH_W(PH_W), .N_PROF(N_PROF), .IVL_W(IVL_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .prof_sel_i, .update_i,
    .act_ftw_o(act_ftw), .prof_q_o(prof_q), .sel_ftw_o(sel_ftw), .sel_poff_o(sel_poff),
    .start_ftw_o(start_ftw), .step_o(sw_step), .end_o(sw_end), .ivl_o(sw_ivl),
    .sweep_en_o(sweep_en)
  );

  nco_sweep #(.FTW_W(FTW_W), .IVL_W(IVL_W)) u_sweep (
    .clk_i, .rst_ni, .load_i(update_i), .en_i(sweep_en), .start_i(start_ftw),
    .step_i(sw_step), .end_i(sw_end), .ivl_i(sw_ivl), .ftw_o(sw_ftw), .tick_o(sw_tick)
  );

  assign ftw_eff = sweep_en ? sw_ftw : sel_ftw;

  nco_accum #(.FTW_W(FTW_W), .PH_W(PH_W)) u_acc (
    .clk_i, .rst_ni, .clr_i(phase_clr_i), .ftw_i(ftw_eff), .poff_i(sel_poff),
    .acc_o(acc_q), .phase_o
  );
endmodule

// File: rtl/nco_checker.sv
module nco_checker #(
  parameter int FTW_W  = 48,
  parameter int N_PROF = 8,
  localparam int SEL_W = $clog2(N_PROF)
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         update_i,
  input logic                         phase_clr_i,
  input logic [SEL_W-1:0]             prof_sel_i,
  input logic [SEL_W-1:0]             prof_q,
  input logic [N_PROF-1:0][FTW_W-1:0] act_ftw,
  input logic [FTW_W-1:0]             acc_q,
  input logic [FTW_W-1:0]             sw_ftw,
  input logic [FTW_W-1:0]             sw_end,
  input logic                         sw_tick
);
  p_active_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(act_ftw));

  p_sel_sample_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> prof_q == $past(prof_sel_i));

  p_clr_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_clr_i |=> acc_q == '0);

  p_sweep_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_tick |=> sw_ftw <= $past(sw_end));
endmodule

bind dds_profile_nco nco_checker #(.FTW_W(FTW_W), .N_PROF(N_PROF)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .update_i(update_i), .phase_clr_i(phase_clr_i),
  .prof_sel_i(prof_sel_i), .prof_q(prof_q), .act_ftw(act_ftw), .acc_q(acc_q),
  .sw_ftw(sw_ftw), .sw_end(sw_end), .sw_tick(sw_tick)
);

// File: tb/tb_dds_profile_nco.sv
`timescale 1ns/1ps
module tb_dds_profile_nco;
  typedef struct packed {
    logic [2:0]  p;
    logic [47:0] f;
    logic [13:0] o;
    logic [7:0]  n;
  } row_t;

  localparam row_t ROWS [8] = '{
    '{3'd0, 48'h0001_2345_6789, 14'h0000, 8'd5},
    '{3'd1, 48'h1000_0000_0000, 14'h0010, 8'd3},
    '{3'd2, 48'hFFFF_FFFF_FFFF, 14'h3FFF, 8'd7},
    '{3'd3, 48'h8000_0000_0000, 14'h2000, 8'd3},
    '{3'd4, 48'h0000_0400_0000, 14'h1234, 8'd9},
    '{3'd5, 48'h7FFF_0000_1234, 14'h0FFF, 8'd4},
    '{3'd6, 48'h0123_4567_89AB, 14'h3F00, 8'd11},
    '{3'd7, 48'h0000_0000_0001, 14'h0001, 8'd2}
  };
  localparam logic [47:0] UNIT = 48'h1 << 34;

  logic        clk = 1'b0, rst_ni = 1'b0, wr_en = 1'b0, update = 1'b0, clr = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [47:0] wr_data = '0;
  logic [2:0]  prof_sel = '0;
  logic [13:0] phase;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  dds_profile_nco dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .prof_sel_i(prof_sel), .update_i(update),
    .phase_clr_i(clr), .phase_o(phase)
  );

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: phase actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [47:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk); update = 1'b1;
    @(negedge clk); update = 1'b0;
  endtask

  // select profile, clear on same edge, then run n edges
  task automatic run(input logic [2:0] p, input int n);
    @(negedge clk); prof_sel = p; clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [13:0] expect_ph(input row_t r);
    logic [47:0] a;
    a = r.f * {40'd0, r.n};
    return a[47:34] + r.o;
  endfunction

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3;
    check("R1 in reset", phase, 14'h0000);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R2: shadow writes without commit stay invisible
    wr(5'h00, UNIT);
    wr(5'h08, 48'd5);
    run(3'd0, 3);
    check("R2 no commit", phase, 14'h0000);

    // R2 R3 R4: program all profiles, commit, walk the table
    for (int i = 0; i < 8; i++) begin
      wr({2'b00, ROWS[i].p}, ROWS[i].f);
      wr({2'b01, ROWS[i].p}, {34'd0, ROWS[i].o});
    end
    commit();
    for (int i = 0; i < 8; i++) begin
      run(ROWS[i].p, int'(ROWS[i].n));
      check($sformatf("R3 R4 profile %0d", ROWS[i].p), phase, expect_ph(ROWS[i]));
    end
    for (int i = 7; i >= 0; i--) begin
      run(ROWS[i].p, int'(ROWS[i].n));
      check($sformatf("R4 reverse profile %0d", ROWS[i].p), phase, expect_ph(ROWS[i]));
    end

    // R5: clear gives offset, registers intact afterwards
    run(3'd2, 4);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check("R5 clear", phase, ROWS[2].o);
    repeat (int'(ROWS[2].n)) @(negedge clk);
    check("R5 regs kept", phase, expect_ph(ROWS[2]));

    // R3: select changes apply one edge after sampling
    run(3'd7, 0);
    check("R3 offset follows select", phase, ROWS[7].o);

    // R6 R7: sweep 1 -> 4 units, step 1 unit, interval 3
    wr(5'h00, UNIT);
    wr(5'h08, 48'd0);
    wr(5'h10, UNIT);
    wr(5'h11, UNIT * 4);
    wr(5'h12, 48'd3);
    wr(5'h13, 48'd1);
    @(negedge clk); prof_sel = 3'd0; update = 1'b1; clr = 1'b1;
    @(negedge clk); update = 1'b0; clr = 1'b0;
    check("R6 sweep start", phase, 14'h0000);
    begin
      logic [13:0] prev, d, e;
      prev = phase;
      for (int j = 1; j <= 16; j++) begin
        @(negedge clk);
        d = phase - prev;
        prev = phase;
        e = (1 + (j - 1) / 3 > 4) ? 14'd4 : 14'(1 + (j - 1) / 3);
        check(j >= 10 ? $sformatf("R7 sat step %0d", j) : $sformatf("R6 ramp step %0d", j), d, e);
      end
      // R8: leave sweep
      wr(5'h13, 48'd0);
      commit();
      prev = phase;
      @(negedge clk);
      d = phase - prev;
      check("R8 sweep off", d, 14'd1);
    end

    // R1: reset mid-run clears everything
    @(negedge clk); rst_ni = 1'b0;
    #1 check("R1 async clear", phase, 14'h0000);
    @(negedge clk); rst_ni = 1'b1;
    commit();
    @(negedge clk); prof_sel = 3'd5;
    repeat (4) @(negedge clk);
    check("R1 regs cleared", phase, 14'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule